// File: doc/BRIEF.md
# Set-Associative Translation Buffer

This block caches virtual-to-physical page translations for one level of a multi-level GPU address translation hierarchy. Pages are 4 KB. The virtual page number selects a set through its low bits. Each way of a set holds a valid flag, a global flag, an address-space number, the full virtual page number, a physical page number and three permission bits. A lookup returns hit or miss a fixed number of cycles after it is accepted, and one lookup can start every cycle. On a miss, the outcome code tells the requester where the request goes next. A last-level instance sends it to the page walker. Any other instance sends it to the next buffer level.

Translations come back on a fill port. Each fill carries the outcome code that produced it. The fill is echoed to the requester on a return port, and a fill that came back from a lower buffer level takes one extra cycle on that path. Whether a fill is allocated locally depends on its code and on a policy parameter. Replacement follows true least-recently-used order within each set, and free ways are always used before any entry is evicted. Three maintenance commands are provided: flush everything, flush only non-global entries, and remove one page qualified by its address-space number.

Top module: `tlb_set_assoc`

## Requirements
- R1: A lookup accepted on a clock edge produces rsp_valid exactly HIT_LAT edges later, and lookups may be accepted on consecutive cycles. A hit requires an entry that is valid, has the same virtual page number (va[VA_W-1:12]), and is either global or has the same ASN. The response carries that entry's PPN and its perm field {uncacheable, user, writable}.
- R2: The outcome code is 0 for hit, 1 for miss, 2 for page-walk result and 3 for miss-return. A lookup hit answers with code 0. A miss answers with code 2 when LAST_LEVEL=1 and code 1 otherwise.
- R3: The set is the virtual page number modulo SETS. The 12 page-offset bits take no part in matching. SETS=1 gives a fully associative buffer.
- R4: Within a set, the ways hold distinct recency ranks, and rank 0 is the most recently used. A hit with lk_touch=1 moves the entry to rank 0. A hit with lk_touch=0 leaves the order unchanged.
- R5: An allocated fill is placed in one of three ways, checked in this order: the way whose entry already matches it (by the R1 rule using the fill ASN), else the lowest-numbered invalid way, else the way with the oldest rank. The written way becomes most recently used. An evicted entry is simply dropped.
- R6: A fill with code 2 is always allocated. A fill with code 3 is allocated only when ALLOC_ON_RETURN=1. Fills with code 0 or 1 are never allocated.
- R7: inv_all clears every entry. inv_local clears only entries whose global flag is 0. demap clears only entries whose VPN and ASN both equal demap_va's page and demap_asn.
- R8: If any invalidation command is present in the same cycle as a fill, the fill is not written. A lookup accepted in the same cycle as an invalidation sees the old contents. A lookup accepted one cycle later sees the cleared state.
- R9: Every fill is returned on ret_* with its code, PPN and perm. The return appears one edge after the fill for codes 0 to 2, and two edges after the fill for code 3.
- R10: After reset, no entry is valid, and rsp_valid and ret_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_touch | input | 1 | Update recency on hit |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_code | output | 2 | Outcome code |
| rsp_ppn | output | PPN_W | Physical page on hit |
| rsp_perm | output | 3 | {uncacheable, user, writable} on hit |
| fill_valid | input | 1 | Fill request |
| fill_va | input | VA_W | Fill virtual address |
| fill_asn | input | ASN_W | Fill address-space number |
| fill_global | input | 1 | Fill global flag |
| fill_ppn | input | PPN_W | Fill physical page |
| fill_perm | input | 3 | Fill permissions |
| fill_code | input | 2 | Outcome that produced the fill |
| inv_all | input | 1 | Clear all entries |
| inv_local | input | 1 | Clear non-global entries |
| demap | input | 1 | Clear one page |
| demap_va | input | VA_W | Page to clear |
| demap_asn | input | ASN_W | ASN of page to clear |
| ret_valid | output | 1 | Fill returned to requester |
| ret_code | output | 2 | Returned outcome code |
| ret_ppn | output | PPN_W | Returned physical page |
| ret_perm | output | 3 | Returned permissions |

## Verification
Two kinds of events can land in the same cycle: an invalidation with a fill, and an invalidation with a lookup. The bench drives a fill and a non-global flush together and then looks the page up, expecting a miss while the return port still echoes the fill. It also presents a lookup in the same cycle as a full flush, expecting the old hit, and then presents a second lookup one cycle later, expecting a miss. Random traffic is compared against a reference model in the bench. That traffic crowds a small set of pages into few sets, so evictions and recency ordering are exercised constantly.

// File: rtl/tlb_set_assoc.sv
module tlb_set_assoc #(
  parameter int VA_W = 32,
  parameter int PPN_W = 20,
  parameter int ASN_W = 8,
  parameter int SETS = 4,
  parameter int WAYS = 4,
  parameter int HIT_LAT = 2,
  parameter int LAST_LEVEL = 1,
  parameter int ALLOC_ON_RETURN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [ASN_W-1:0] lk_asn,
  input  logic             lk_touch,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [1:0]       rsp_code,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic [2:0]       rsp_perm,
  input  logic             fill_valid,
  input  logic [VA_W-1:0]  fill_va,
  input  logic [ASN_W-1:0] fill_asn,
  input  logic             fill_global,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [2:0]       fill_perm,
  input  logic [1:0]       fill_code,
  input  logic             inv_all,
  input  logic             inv_local,
  input  logic             demap,
  input  logic [VA_W-1:0]  demap_va,
  input  logic [ASN_W-1:0] demap_asn,
  output logic             ret_valid,
  output logic [1:0]       ret_code,
  output logic [PPN_W-1:0] ret_ppn,
  output logic [2:0]       ret_perm
);
  localparam int VPN_W = VA_W - 12;
  localparam int RK_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int ENT = SETS * WAYS;
  localparam logic [1:0] C_HIT = 2'd0, C_MISS = 2'd1, C_WALK = 2'd2, C_MRET = 2'd3;

  logic             e_v    [ENT];
  logic             e_g    [ENT];
  logic [ASN_W-1:0] e_asn  [ENT];
  logic [VPN_W-1:0] e_vpn  [ENT];
  logic [PPN_W-1:0] e_ppn  [ENT];
  logic [2:0]       e_perm [ENT];
  logic [RK_W-1:0]  e_rank [ENT];

  function automatic int base_of(input logic [VPN_W-1:0] vpn);
    return int'(32'(vpn) % SETS) * WAYS;
  endfunction

  logic [VPN_W-1:0] lk_vpn, f_vpn, dm_vpn;
  assign lk_vpn = lk_va[VA_W-1:12];
  assign f_vpn  = fill_va[VA_W-1:12];
  assign dm_vpn = demap_va[VA_W-1:12];

  int lk_b, f_b, t_b;
  logic lk_hit;
  logic [RK_W-1:0] lk_way;
  logic [PPN_W-1:0] lk_ppn;
  logic [2:0] lk_perm;

  always_comb begin
    lk_b = base_of(lk_vpn);
    lk_hit = 1'b0; lk_way = '0; lk_ppn = '0; lk_perm = '0;
    for (int w = 0; w < WAYS; w++)
      if (e_v[lk_b+w] && e_vpn[lk_b+w] == lk_vpn && (e_g[lk_b+w] || e_asn[lk_b+w] == lk_asn)) begin
        lk_hit = 1'b1; lk_way = RK_W'(w); lk_ppn = e_ppn[lk_b+w]; lk_perm = e_perm[lk_b+w];
      end
  end

  logic f_hit, f_free, f_alloc, inv_any;
  logic [RK_W-1:0] f_hitway, f_freeway, f_lruway, f_way;

  always_comb begin
    f_b = base_of(f_vpn);
    f_hit = 1'b0; f_free = 1'b0; f_hitway = '0; f_freeway = '0; f_lruway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (e_v[f_b+w] && e_vpn[f_b+w] == f_vpn && (e_g[f_b+w] || e_asn[f_b+w] == fill_asn)) begin
        f_hit = 1'b1; f_hitway = RK_W'(w);
      end
      if (!e_v[f_b+w]) begin f_free = 1'b1; f_freeway = RK_W'(w); end
      if (e_rank[f_b+w] == RK_W'(WAYS - 1)) f_lruway = RK_W'(w);
    end
  end

  assign f_way   = f_hit ? f_hitway : (f_free ? f_freeway : f_lruway);
  assign inv_any = inv_all | inv_local | demap;
  assign f_alloc = fill_valid && !inv_any &&
                   (fill_code == C_WALK || (fill_code == C_MRET && ALLOC_ON_RETURN != 0));

  logic t_en;
  logic [RK_W-1:0] t_way, t_rank;
  assign t_en   = f_alloc | (lk_valid & lk_hit & lk_touch);
  assign t_b    = f_alloc ? f_b : lk_b;
  assign t_way  = f_alloc ? f_way : lk_way;
  assign t_rank = e_rank[t_b + int'(t_way)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENT; e++) begin
        e_v[e] <= 1'b0; e_g[e] <= 1'b0; e_asn[e] <= '0; e_vpn[e] <= '0;
        e_ppn[e] <= '0; e_perm[e] <= '0; e_rank[e] <= RK_W'(e % WAYS);
      end
    end else begin
      for (int e = 0; e < ENT; e++)
        if (inv_all || (inv_local && !e_g[e]) ||
            (demap && e_vpn[e] == dm_vpn && e_asn[e] == demap_asn))
          e_v[e] <= 1'b0;
      if (f_alloc) begin
        e_v[f_b + int'(f_way)]    <= 1'b1;
        e_g[f_b + int'(f_way)]    <= fill_global;
        e_asn[f_b + int'(f_way)]  <= fill_asn;
        e_vpn[f_b + int'(f_way)]  <= f_vpn;
        e_ppn[f_b + int'(f_way)]  <= fill_ppn;
        e_perm[f_b + int'(f_way)] <= fill_perm;
      end
      if (t_en)
        for (int w = 0; w < WAYS; w++)
          if (RK_W'(w) == t_way) e_rank[t_b+w] <= '0;
          else if (e_rank[t_b+w] < t_rank) e_rank[t_b+w] <= e_rank[t_b+w] + 1'b1;
    end
  end

  logic             p_v    [HIT_LAT];
  logic             p_h    [HIT_LAT];
  logic [PPN_W-1:0] p_ppn  [HIT_LAT];
  logic [2:0]       p_perm [HIT_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HIT_LAT; i++) begin
        p_v[i] <= 1'b0; p_h[i] <= 1'b0; p_ppn[i] <= '0; p_perm[i] <= '0;
      end
    end else begin
      p_v[0] <= lk_valid; p_h[0] <= lk_valid & lk_hit;
      p_ppn[0] <= lk_ppn; p_perm[0] <= lk_perm;
      for (int i = 1; i < HIT_LAT; i++) begin
        p_v[i] <= p_v[i-1]; p_h[i] <= p_h[i-1];
        p_ppn[i] <= p_ppn[i-1]; p_perm[i] <= p_perm[i-1];
      end
    end
  end

  assign rsp_valid = p_v[HIT_LAT-1];
  assign rsp_hit   = p_h[HIT_LAT-1];
  assign rsp_code  = p_h[HIT_LAT-1] ? C_HIT : ((LAST_LEVEL != 0) ? C_WALK : C_MISS);
  assign rsp_ppn   = p_ppn[HIT_LAT-1];
  assign rsp_perm  = p_perm[HIT_LAT-1];

  logic r1_v, r2_v;
  logic [1:0] r1_code, r2_code;
  logic [PPN_W-1:0] r1_ppn, r2_ppn;
  logic [2:0] r1_perm, r2_perm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r1_v <= 1'b0; r2_v <= 1'b0; r1_code <= '0; r2_code <= '0;
      r1_ppn <= '0; r2_ppn <= '0; r1_perm <= '0; r2_perm <= '0;
    end else begin
      r1_v <= fill_valid; r1_code <= fill_code; r1_ppn <= fill_ppn; r1_perm <= fill_perm;
      r2_v <= r1_v && r1_code == C_MRET; r2_code <= r1_code; r2_ppn <= r1_ppn; r2_perm <= r1_perm;
    end
  end

  assign ret_valid = r2_v || (r1_v && r1_code != C_MRET);
  assign ret_code  = r2_v ? r2_code : r1_code;
  assign ret_ppn   = r2_v ? r2_ppn : r1_ppn;
  assign ret_perm  = r2_v ? r2_perm : r1_perm;

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_mru
      logic [WAYS-1:0] mru;
      for (genvar w = 0; w < WAYS; w++) begin : g_w
        assign mru[w] = (e_rank[s*WAYS+w] == '0);
      end
      a_r4_one_mru: assert property (@(posedge clk) disable iff (!rst_n) $onehot(mru));
    end
  endgenerate

  a_r8_flush_seen: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !(lk_valid && lk_hit));
  a_r2_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_code == ((LAST_LEVEL != 0) ? C_WALK : C_MISS));
  a_r9_ret_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_code != C_MRET) |=> (ret_valid && ret_code != C_MRET));
  a_r9_ret_delayed: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_code == C_MRET) |=> !ret_valid ##1 (ret_valid && ret_code == C_MRET));
endmodule

// File: tb/tlb_set_assoc_tb.sv
module tlb_set_assoc_tb_top;
  localparam int HL = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_touch = 0, fill_valid = 0, fill_global = 0;
  logic inv_all = 0, inv_local = 0, demap = 0;
  logic [31:0] lk_va = 0, fill_va = 0, demap_va = 0;
  logic [7:0] lk_asn = 0, fill_asn = 0, demap_asn = 0;
  logic [19:0] fill_ppn = 0;
  logic [2:0] fill_perm = 0;
  logic [1:0] fill_code = 0;
  logic rsp_valid, rsp_hit, ret_valid;
  logic [1:0] rsp_code, ret_code;
  logic [19:0] rsp_ppn, ret_ppn;
  logic [2:0] rsp_perm, ret_perm;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tlb_set_assoc dut_i (.*);

  bit m_v[16]; bit m_g[16]; logic [7:0] m_asn[16]; logic [19:0] m_vpn[16];
  logic [19:0] m_ppn[16]; logic [2:0] m_perm[16]; int m_rank[16];

  task automatic chk(bit ok, string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s got=%0h exp=%0h", req, got, exp); end
  endtask

  function automatic int mfind(logic [19:0] vpn, logic [7:0] asn);
    int b = int'(vpn % 4) * 4;
    for (int w = 0; w < 4; w++)
      if (m_v[b+w] && m_vpn[b+w] == vpn && (m_g[b+w] || m_asn[b+w] == asn)) return b + w;
    return -1;
  endfunction

  task automatic mtouch(int e);
    int b = e - e % 4; int r = m_rank[e];
    for (int w = 0; w < 4; w++)
      if (b + w == e) m_rank[b+w] = 0;
      else if (m_rank[b+w] < r) m_rank[b+w]++;
  endtask

  task automatic mreset();
    for (int e = 0; e < 16; e++) begin m_v[e] = 0; m_rank[e] = e % 4; end
  endtask

  task automatic lookup(logic [31:0] va, logic [7:0] asn, bit touch, string req);
    int e = mfind(va[31:12], asn);
    @(negedge clk); lk_valid = 1; lk_va = va; lk_asn = asn; lk_touch = touch;
    @(negedge clk); lk_valid = 0;
    repeat (HL - 1) @(negedge clk);
    chk(rsp_valid === 1'b1, req, rsp_valid, 1);
    chk(rsp_hit === (e >= 0), req, rsp_hit, e >= 0);
    chk(rsp_code === ((e >= 0) ? 2'd0 : 2'd2), {req, " R2"}, rsp_code, (e >= 0) ? 0 : 2);
    if (e >= 0) begin
      chk(rsp_ppn === m_ppn[e] && rsp_perm === m_perm[e], {req, " R1"},
          {rsp_perm, rsp_ppn}, {m_perm[e], m_ppn[e]});
      if (touch) mtouch(e);
    end
  endtask

  task automatic mfill(logic [31:0] va, logic [7:0] asn, bit g, logic [19:0] ppn,
                       logic [2:0] perm, logic [1:0] code);
    int e = mfind(va[31:12], asn);
    int b = int'(va[31:12] % 4) * 4;
    if (!(code == 2 || code == 3)) return;
    if (e < 0) for (int w = 3; w >= 0; w--) if (!m_v[b+w]) e = b + w;
    if (e < 0) for (int w = 0; w < 4; w++) if (m_rank[b+w] == 3) e = b + w;
    m_v[e] = 1; m_g[e] = g; m_asn[e] = asn; m_vpn[e] = va[31:12];
    m_ppn[e] = ppn; m_perm[e] = perm; mtouch(e);
  endtask

  task automatic fill(logic [31:0] va, logic [7:0] asn, bit g, logic [19:0] ppn,
                      logic [2:0] perm, logic [1:0] code, bit with_inv_local);
    if (with_inv_local) begin
      for (int e = 0; e < 16; e++) if (!m_g[e]) m_v[e] = 0;
    end else mfill(va, asn, g, ppn, perm, code);
    @(negedge clk); fill_valid = 1; fill_va = va; fill_asn = asn; fill_global = g;
    fill_ppn = ppn; fill_perm = perm; fill_code = code; inv_local = with_inv_local;
    @(negedge clk); fill_valid = 0; inv_local = 0;
    if (code == 3) begin
      chk(ret_valid === 1'b0, "R9 early", ret_valid, 0);
      @(negedge clk);
    end
    chk(ret_valid === 1'b1 && ret_code === code && ret_ppn === ppn && ret_perm === perm,
        "R9 return", {ret_valid, ret_code, ret_perm, ret_ppn}, {1'b1, code, perm, ppn});
  endtask

  task automatic invalidate(int kind, logic [31:0] va, logic [7:0] asn);
    for (int e = 0; e < 16; e++)
      if (kind == 0 || (kind == 1 && !m_g[e]) ||
          (kind == 2 && m_vpn[e] == va[31:12] && m_asn[e] == asn)) m_v[e] = 0;
    @(negedge clk); inv_all = (kind == 0); inv_local = (kind == 1); demap = (kind == 2);
    demap_va = va; demap_asn = asn;
    @(negedge clk); inv_all = 0; inv_local = 0; demap = 0;
  endtask

  function automatic logic [31:0] mkva(int vpn);
    return {20'(vpn), 12'($urandom % 4096)};
  endfunction

  initial begin
    void'($urandom(32'd7351));
    mreset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && ret_valid === 1'b0, "R10 reset", {rsp_valid, ret_valid}, 0);
    lookup(mkva(5), 8'd1, 1, "R10 empty");

    fill(32'h0000_1abc, 8'd1, 0, 20'h11111, 3'b101, 2'd2, 0);
    lookup(32'h0000_1fff, 8'd1, 1, "R3 offset ignored");
    lookup(32'h0000_1000, 8'd2, 1, "R1 asn mismatch");
    fill(32'h0000_2000, 8'd1, 1, 20'h22222, 3'b011, 2'd2, 0);
    lookup(32'h0000_2000, 8'd9, 1, "R1 global any asn");

    @(negedge clk); lk_valid = 1; lk_va = 32'h0000_1000; lk_asn = 8'd1; lk_touch = 0;
    @(negedge clk); lk_va = 32'h0000_3000;
    @(negedge clk); lk_valid = 0;
    chk(rsp_valid && rsp_hit && rsp_ppn == 20'h11111, "R1 pipelined first", rsp_ppn, 20'h11111);
    @(negedge clk);
    chk(rsp_valid && !rsp_hit, "R1 pipelined second", rsp_hit, 0);

    fill(32'h0000_5000, 8'd1, 0, 20'h55555, 3'b001, 2'd0, 0);
    lookup(32'h0000_5000, 8'd1, 0, "R6 code0 no alloc");
    fill(32'h0000_5000, 8'd1, 0, 20'h55556, 3'b001, 2'd3, 0);
    lookup(32'h0000_5000, 8'd1, 0, "R6 code3 alloc");

    invalidate(0, 0, 0);
    for (int i = 0; i < 4; i++) fill(mkva(i * 4), 8'd3, 0, 20'(100 + i), 3'b000, 2'd2, 0);
    lookup(mkva(0), 8'd3, 1, "R4 touch");
    fill(mkva(16), 8'd3, 0, 20'd200, 3'b111, 2'd2, 0);
    lookup(mkva(4), 8'd3, 0, "R5 lru evicted");
    lookup(mkva(0), 8'd3, 0, "R4 mru kept");
    lookup(mkva(16), 8'd3, 0, "R5 new entry");
    fill(mkva(8), 8'd3, 0, 20'd300, 3'b010, 2'd2, 0);
    lookup(mkva(8), 8'd3, 0, "R5 overwrite match");

    fill(32'h0000_9000, 8'd4, 1, 20'h9, 3'b0, 2'd2, 0);
    invalidate(1, 0, 0);
    lookup(32'h0000_9000, 8'd4, 0, "R7 global survives");
    lookup(mkva(0), 8'd3, 0, "R7 local flushed");
    fill(32'h0000_a000, 8'd4, 0, 20'ha, 3'b0, 2'd2, 0);
    invalidate(2, 32'h0000_a000, 8'd5);
    lookup(32'h0000_a000, 8'd4, 0, "R7 demap asn mismatch");
    invalidate(2, 32'h0000_a000, 8'd4);
    lookup(32'h0000_a000, 8'd4, 0, "R7 demap match");

    fill(32'h0000_b000, 8'd4, 0, 20'hb, 3'b0, 2'd2, 1);
    lookup(32'h0000_b000, 8'd4, 0, "R8 fill dropped");

    @(negedge clk); lk_valid = 1; lk_va = 32'h0000_9000; lk_asn = 8'd4; lk_touch = 0; inv_all = 1;
    @(negedge clk); inv_all = 0;
    @(negedge clk); lk_valid = 0;
    chk(rsp_valid && rsp_hit, "R8 same-cycle old", rsp_hit, 1);
    @(negedge clk);
    chk(rsp_valid && !rsp_hit, "R8 next-cycle cleared", rsp_hit, 0);
    mreset();
    for (int e = 0; e < 16; e++) m_v[e] = 0;

    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 10;
      int vpn = $urandom % 24;
      logic [7:0] asn = 8'($urandom % 3);
      if (op < 4) lookup(mkva(vpn), asn, 1'($urandom), "R4 random lookup");
      else if (op < 8) fill(mkva(vpn), asn, ($urandom % 5) == 0, 20'($urandom),
                            3'($urandom), 2'($urandom), 0);
      else if (op == 8) invalidate(2, mkva(vpn), asn);
      else invalidate(($urandom % 4 == 0) ? 0 : 1, 0, 0);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog got=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule